// File: doc/BRIEF.md
# Six-Phase Multicycle Instruction Sequencer

This block is a small multicycle execution core. It runs 16-bit instructions one at a time. Each instruction passes through up to six phases: fetch, decode, evaluate address, fetch operands, execute and store result. The core holds a program counter, an instruction register and an eight-entry register file. It reads instructions over a synchronous instruction-memory port. The memory returns the addressed word one clock after the core requests it.

Three instruction kinds are executed:

- A register-register add.
- An add with a sign-extended 5-bit immediate.
- An address-forming instruction. This is the only memory-class kind. It computes a base register plus an immediate in the evaluate-address phase, then writes that address to a register.

Non-memory instructions skip the evaluate-address phase. Any other opcode is retired as a no-op after decode. The current phase is visible on an output, and every register write is reported on a write-back port. A system observes progress and results through these two outputs.

Top module: `phase_core`

## Requirements
- R1: While reset is asserted the phase output is 0 (fetch), the instruction address is 0 and no write-back is signalled. After reset every register of the file reads as 0.
- R2: The instruction-memory request is high only in the fetch phase, and the requested address is the program counter. The program counter advances by one per fetch, wrapping modulo 2^PC_W, and holds in every other phase.
- R3: Phase codes are fetch=0, decode=1, evaluate address=2, fetch operands=3, execute=4, store result=5. Phases only move forward in this order, and store result is followed by fetch.
- R4: Opcode 5'b00010 (register add) runs the phases 0,1,3,4,5, so it takes five cycles with no evaluate-address cycle. It writes rf[SR] + rf[SR2] modulo 2^16 to DR.
- R5: Opcode 5'b00011 (immediate add) runs the phases 0,1,3,4,5. It writes rf[SR] plus the 5-bit two's-complement immediate (-16..15), sign-extended to 16 bits, modulo 2^16 to DR.
- R6: Opcode 5'b00110 (address form) runs all six phases 0,1,2,3,4,5. It writes rf[SR] + sign-extended immediate to DR.
- R7: Any other opcode runs phases 0,1 and then returns to fetch. It signals no write-back and leaves every register unchanged.
- R8: Write-back is valid for exactly one cycle per writing instruction, during the store-result phase. Its address is DR and its data is the result. The written value is seen by the operand reads of the next instruction.
- R9: Field layout: opcode [15:11], DR [10:8], SR [7:5], immediate [4:0], and SR2 [4:2] for the register add. Bits [1:0] of a register add have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_en | output | 1 | Instruction read request |
| imem_addr | output | PC_W | Instruction address (program counter) |
| imem_rdata | input | 16 | Instruction word, valid the cycle after the request |
| phase_o | output | 3 | Current phase code |
| wb_valid | output | 1 | Register write in this cycle |
| wb_addr | output | 3 | Register being written |
| wb_data | output | DATA_W | Value being written |

## Verification
The instruction word requested in a fetch cycle appears on the memory port in the following decode cycle. The result of an add reaches the write-back port in the fourth cycle after its fetch cycle. The address-form instruction needs one more cycle, so its result arrives in the fifth cycle after fetch. A no-op is followed by the next fetch in the second cycle after its own fetch.

The bench walks each instruction cycle by cycle along the phase list its opcode implies. At every falling edge it compares the phase output, the fetch address and the write-back port against values held in a reference register array. The array is updated only after the store-result comparison, so every check reads the value its requirement defines at that cycle.

// File: rtl/phase_pkg.sv
package phase_pkg;

   localparam int INSTR_W = 16;
   localparam int OP_W    = 5;
   localparam int IMM_W   = 5;

   typedef enum logic [2:0] {
      PH_FETCH  = 3'd0,
      PH_DECODE = 3'd1,
      PH_EVAL   = 3'd2,
      PH_OPER   = 3'd3,
      PH_EXEC   = 3'd4,
      PH_STORE  = 3'd5
   } phase_e;

   typedef enum logic [1:0] {
      K_NOP  = 2'd0,
      K_ADDR = 2'd1,
      K_ADDI = 2'd2,
      K_LEA  = 2'd3
   } kind_e;

   localparam logic [OP_W-1:0] OPC_ADD_REG = 5'b00010;
   localparam logic [OP_W-1:0] OPC_ADD_IMM = 5'b00011;
   localparam logic [OP_W-1:0] OPC_ADDR_FM = 5'b00110;

   function automatic kind_e classify(input logic [OP_W-1:0] op);
      case (op)
         OPC_ADD_REG: classify = K_ADDR;
         OPC_ADD_IMM: classify = K_ADDI;
         OPC_ADDR_FM: classify = K_LEA;
         default:     classify = K_NOP;
      endcase
   endfunction

endpackage

// File: rtl/phase_seq.sv
module phase_seq
   import phase_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] dec_op,
   output phase_e          phase,
   output kind_e           kind
);

   phase_e phase_d;
   kind_e  dec_kind;

   assign dec_kind = classify(dec_op);

   always_comb begin
      case (phase)
         PH_FETCH:  phase_d = PH_DECODE;
         PH_DECODE: begin
            case (dec_kind)
               K_NOP:   phase_d = PH_FETCH;
               K_LEA:   phase_d = PH_EVAL;
               default: phase_d = PH_OPER;
            endcase
         end
         PH_EVAL:   phase_d = PH_OPER;
         PH_OPER:   phase_d = PH_EXEC;
         PH_EXEC:   phase_d = PH_STORE;
         default:   phase_d = PH_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_FETCH;
         kind  <= K_NOP;
      end else begin
         phase <= phase_d;
         if (phase == PH_DECODE) kind <= dec_kind;
      end
   end

endmodule

// File: rtl/phase_rf.sv
module phase_rf #(
   parameter int DATA_W = 16,
   parameter int NREG   = 8,
   localparam int RA_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RA_W-1:0]   ra1,
   input  logic [RA_W-1:0]   ra2,
   output logic [DATA_W-1:0] rd1,
   output logic [DATA_W-1:0] rd2,
   input  logic              we,
   input  logic [RA_W-1:0]   wa,
   input  logic [DATA_W-1:0] wd
);

   logic [DATA_W-1:0] regs_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      end else if (we) begin
         regs_q[wa] <= wd;
      end
   end

   assign rd1 = regs_q[ra1];
   assign rd2 = regs_q[ra2];

endmodule

// File: rtl/phase_alu.sv
module phase_alu #(
   parameter int DATA_W    = 16,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum
);

   localparam int LO_W = DATA_W / 2;
   localparam int HI_W = DATA_W - LO_W;

   if (SPLIT_ADD) begin : g_split
      logic [LO_W:0]   lo;
      logic [HI_W-1:0] hi;
      assign lo  = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
      assign hi  = a[DATA_W-1:LO_W] + b[DATA_W-1:LO_W] + HI_W'(lo[LO_W]);
      assign sum = {hi, lo[LO_W-1:0]};
   end else begin : g_flat
      assign sum = a + b;
   end

endmodule

// File: rtl/phase_core.sv
module phase_core
   import phase_pkg::*;
#(
   parameter int PC_W      = 8,
   parameter int DATA_W    = 16,
   parameter int NREG      = 8,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               imem_en,
   output logic [PC_W-1:0]    imem_addr,
   input  logic [15:0]        imem_rdata,
   output logic [2:0]         phase_o,
   output logic               wb_valid,
   output logic [2:0]         wb_addr,
   output logic [DATA_W-1:0]  wb_data
);

   localparam int RA_W   = $clog2(NREG);
   localparam int BODY_W = INSTR_W - OP_W;

   if (NREG != 8) begin : g_bad_nreg
      $error("phase_core: register fields are 3 bits, NREG must be 8");
   end
   if (DATA_W <= IMM_W) begin : g_bad_data
      $error("phase_core: DATA_W must exceed the immediate width");
   end
   if (PC_W < 1) begin : g_bad_pc
      $error("phase_core: PC_W must be positive");
   end

   phase_e             phase;
   kind_e              kind;
   logic [PC_W-1:0]    pc_q;
   logic [BODY_W-1:0]  ir_q;
   logic [DATA_W-1:0]  ea_q, opa_q, opb_q, res_q;
   logic [DATA_W-1:0]  rd1, rd2, imm_ext, alu_a, alu_b, alu_sum;
   logic [RA_W-1:0]    f_dr, f_sr, f_sr2;

   // field slicing from the stored word body (opcode handled at decode)
   assign f_dr    = ir_q[10:8];
   assign f_sr    = ir_q[7:5];
   assign f_sr2   = ir_q[4:2];
   assign imm_ext = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

   phase_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .dec_op (imem_rdata[15:11]),
      .phase  (phase),
      .kind   (kind)
   );

   phase_rf #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra1   (f_sr),
      .ra2   (f_sr2),
      .rd1   (rd1),
      .rd2   (rd2),
      .we    (phase == PH_STORE),
      .wa    (f_dr),
      .wd    (res_q)
   );

   // one adder shared by evaluate-address and execute
   assign alu_a = (phase == PH_EVAL) ? rd1     : opa_q;
   assign alu_b = (phase == PH_EVAL) ? imm_ext : opb_q;

   phase_alu #(.DATA_W(DATA_W), .SPLIT_ADD(SPLIT_ADD)) u_alu (
      .a   (alu_a),
      .b   (alu_b),
      .sum (alu_sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         ir_q  <= '0;
         ea_q  <= '0;
         opa_q <= '0;
         opb_q <= '0;
         res_q <= '0;
      end else begin
         case (phase)
            PH_FETCH:  pc_q <= pc_q + PC_W'(1);
            PH_DECODE: ir_q <= imem_rdata[BODY_W-1:0];
            PH_EVAL:   ea_q <= alu_sum;
            PH_OPER: begin
               opa_q <= (kind == K_LEA) ? ea_q : rd1;
               case (kind)
                  K_ADDR:  opb_q <= rd2;
                  K_ADDI:  opb_q <= imm_ext;
                  default: opb_q <= '0;
               endcase
            end
            PH_EXEC:   res_q <= alu_sum;
            default:   ;
         endcase
      end
   end

   assign imem_en   = (phase == PH_FETCH);
   assign imem_addr = pc_q;
   assign phase_o   = phase;
   assign wb_valid  = (phase == PH_STORE);
   assign wb_addr   = f_dr;
   assign wb_data   = res_q;

endmodule

// File: rtl/phase_core_chk.sv
module phase_core_chk
   import phase_pkg::*;
#(
   parameter int PC_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      phase_o,
   input logic [PC_W-1:0] imem_addr,
   input logic [4:0]      op_i,
   input logic            wb_valid
);

   // R3
   fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 3'd0 |=> phase_o == 3'd1);
   // R3
   eval_to_oper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 3'd2 |=> phase_o == 3'd3);
   // R3
   oper_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 3'd3 |=> phase_o == 3'd4);
   // R3
   exec_to_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 3'd4 |=> phase_o == 3'd5);
   // R3
   store_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 3'd5 |=> phase_o == 3'd0);
   // R4
   add_skips_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd1 && (op_i == 5'b00010 || op_i == 5'b00011)) |=> phase_o == 3'd3);
   // R6
   addr_form_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd1 && op_i == 5'b00110) |=> phase_o == 3'd2);
   // R7
   nop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd1 && op_i != 5'b00010 && op_i != 5'b00011 && op_i != 5'b00110)
      |=> phase_o == 3'd0);
   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 3'd0 |=> imem_addr == $past(imem_addr) + PC_W'(1));
   // R2
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o != 3'd0 |=> $stable(imem_addr));
   // R8
   wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid);

endmodule

bind phase_core phase_core_chk #(.PC_W(PC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .phase_o   (phase_o),
   .imem_addr (imem_addr),
   .op_i      (imem_rdata[15:11]),
   .wb_valid  (wb_valid)
);

// File: tb/sim_phase_core.sv
`timescale 1ns/1ps
module sim_phase_core;

   localparam int PC_W   = 8;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 1 << PC_W;
   localparam int N_RUN  = 300;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              imem_en;
   logic [PC_W-1:0]   imem_addr;
   logic [15:0]       imem_rdata = '0;
   logic [2:0]        phase_o;
   logic              wb_valid;
   logic [2:0]        wb_addr;
   logic [DATA_W-1:0] wb_data;

   logic [15:0]       mem [DEPTH];
   logic [15:0]       exp_rf [8];
   int                checks = 0;
   int                fails  = 0;
   int                cyc    = 0;
   bit                done   = 1'b0;

   always #2.5 clk = ~clk;

   phase_core #(.PC_W(PC_W), .DATA_W(DATA_W)) u0 (
      .clk, .rst_n, .imem_en, .imem_addr, .imem_rdata,
      .phase_o, .wb_valid, .wb_addr, .wb_data
   );

   always @(posedge clk) if (imem_en) imem_rdata <= mem[imem_addr];

   function automatic logic [15:0] enc(input logic [4:0] op, input logic [2:0] dr,
                                       input logic [2:0] sr, input logic [4:0] lo);
      return {op, dr, sr, lo};
   endfunction

   function automatic logic [15:0] sx5(input logic [4:0] v);
      return {{11{v[4]}}, v};
   endfunction

   // 0 nop, 1 reg add, 2 imm add, 3 address form
   function automatic int kind_of(input logic [4:0] op);
      if (op == 5'b00010) return 1;
      if (op == 5'b00011) return 2;
      if (op == 5'b00110) return 3;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic run_instr(input int k);
      logic [15:0] w;
      int          kd, n;
      int          ph [6];
      logic [15:0] expv;
      string       req;
      w  = mem[k % DEPTH];
      kd = kind_of(w[15:11]);
      case (kd)
         1: begin n = 5; ph = '{0,1,3,4,5,0}; req = "R4";
                  expv = exp_rf[w[7:5]] + exp_rf[w[4:2]]; end
         2: begin n = 5; ph = '{0,1,3,4,5,0}; req = "R5";
                  expv = exp_rf[w[7:5]] + sx5(w[4:0]); end
         3: begin n = 6; ph = '{0,1,2,3,4,5}; req = "R6";
                  expv = exp_rf[w[7:5]] + sx5(w[4:0]); end
         default: begin n = 2; ph = '{0,1,0,0,0,0}; req = "R7"; expv = '0; end
      endcase
      for (int c = 0; c < n; c++) begin
         chk(phase_o == 3'(ph[c]), req, "phase R3", phase_o, ph[c]);
         if (c == 0) begin
            chk(imem_en == 1'b1, "R2", "fetch request", imem_en, 1);
            chk(imem_addr == PC_W'(k % DEPTH), "R2", "fetch address", imem_addr, k % DEPTH);
         end else begin
            chk(imem_en == 1'b0, "R2", "request outside fetch", imem_en, 0);
         end
         if (ph[c] == 5) begin
            chk(wb_valid == 1'b1, "R8", "write-back valid", wb_valid, 1);
            chk(wb_addr == w[10:8], "R8", "write-back address", wb_addr, w[10:8]);
            chk(wb_data == expv, req, "write-back data", wb_data, expv);
         end else begin
            chk(wb_valid == 1'b0, "R8", "no write-back", wb_valid, 0);
         end
         @(posedge clk);
         @(negedge clk);
      end
      if (kd != 0) exp_rf[w[10:8]] = expv;
   endtask

   initial begin
      int sd;
      sd = $urandom(32'd20240611);
      for (int r = 0; r < 8; r++) exp_rf[r] = '0;
      // directed corner cases
      mem[0] = enc(5'b00010, 3'd1, 3'd2, {3'd3, 2'b00}); // R1 zero regs: 0+0
      mem[1] = enc(5'b00011, 3'd1, 3'd0, 5'b01111);      // R5 +15
      mem[2] = enc(5'b00011, 3'd2, 3'd0, 5'b10000);      // R5 -16
      mem[3] = enc(5'b00010, 3'd3, 3'd1, {3'd2, 2'b11}); // R9 low bits ignored
      mem[4] = enc(5'b00010, 3'd4, 3'd3, {3'd3, 2'b00}); // R4 wrap mod 2^16
      mem[5] = enc(5'b00110, 3'd5, 3'd1, 5'b11111);      // R6 base-1
      mem[6] = enc(5'b11111, 3'd5, 3'd0, 5'b00000);      // R7 unknown opcode
      mem[7] = enc(5'b00011, 3'd6, 3'd5, 5'b00000);      // R7 r5 untouched
      mem[8] = enc(5'b00110, 3'd7, 3'd7, 5'b01111);      // R6 zero base
      mem[9] = enc(5'b00011, 3'd1, 3'd1, 5'b00001);      // R8 back-to-back use
      for (int i = 10; i < DEPTH; i++) begin
         logic [4:0] op;
         case ($urandom % 4)
            0: op = 5'b00010;
            1: op = 5'b00011;
            2: op = 5'b00110;
            default: begin
               op = 5'($urandom);
               if (kind_of(op) != 0) op = 5'b10101;
            end
         endcase
         mem[i] = {op, 11'($urandom)};
      end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(phase_o == 3'd0, "R1", "reset phase", phase_o, 0);
      chk(imem_addr == '0, "R1", "reset address", imem_addr, 0);
      chk(wb_valid == 1'b0, "R1", "reset write-back", wb_valid, 0);
      rst_n = 1'b1;
      for (int k = 0; k < N_RUN; k++) run_instr(k);
      finish_run();
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
         finish_run();
      end
   end

endmodule